// File: doc/BRIEF.md
# Bit-Serial NLFSR Block Decryptor

This block recovers a 32-bit plaintext word from a 32-bit ciphertext under a 64-bit key, one cipher round per clock. A single-cycle start strobe loads the ciphertext into a 32-bit state shift register and the key into a 64-bit circular key register. For the next 528 clocks the state shifts left by one bit and a freshly computed feedback bit enters at bit 0, while the key register rotates one place left. After the last round the state register holds the plaintext, busy falls and done pulses for one cycle.

The feedback bit of every round is the XOR of state bit 31, state bit 15, bit 15 of the rotating key register, and a five-input nonlinear lookup over five further state taps. Because the key register rotates in step with the rounds, round r (r = 0..527) consumes bit (15 − r) mod 64 of the loaded key. The handshake is minimal. The caller may raise start only while busy is low, and any start that arrives during a run is dropped.

Top module: `nlfsr_decryptor`

## Requirements
- R1: With rst_n low (asynchronous, active low), busy_o and done_o read 0 and plain_o reads 0, including when reset hits in the middle of a run.
- R2: A start_i seen high at a rising edge while busy_o is low captures cipher_i and key_i, and busy_o reads 1 after that edge.
- R3: After the capture edge, busy_o stays high for exactly 528 clocks. done_o is high for exactly one cycle, in the cycle where busy_o first reads 0 again.
- R4: Each round computes fb = s[31] ^ s[15] ^ k[15] ^ LUT[{s[30],s[25],s[19],s[8],s[0]}] with LUT = 32'h3A5C742E, where s[30] is the most significant index bit. The state becomes {s[30:0], fb} and the key register becomes {k[62:0], k[63]}.
- R5: When done_o is high, plain_o equals the inverse of the 528-round encryption of that plaintext under the same key. The encryption round is fb = x[0] ^ x[16] ^ key[i mod 64] ^ LUT[{x[31],x[26],x[20],x[9],x[1]}], followed by x = {fb, x[31:1]}.
- R6: A start_i raised while busy_o is high, including in the final round, is ignored. The result and the completion cycle are those of the run already in progress.
- R7: Between done_o and the next accepted start, plain_o holds its value and busy_o stays low whatever cipher_i and key_i do.
- R8: A start given in the cycle after done_o begins a new run with the same latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| cipher_i | input | 32 | Ciphertext word, captured at start |
| key_i | input | 64 | Key, captured at start |
| busy_o | output | 1 | High while rounds are running |
| done_o | output | 1 | One-cycle completion pulse |
| plain_o | output | 32 | State register; holds the plaintext after done |

## Verification
A wrong nonlinear table entry, a misplaced tap or a key rotation in the wrong direction does not show at the ports until done_o. Because every bit then passes through hundreds of rounds of diffusion, about half of plain_o's bits come out wrong, which a check against a reference model and an encrypt/decrypt round trip expose at once. Counter faults show up as a completion cycle other than 528 or a done pulse wider than one cycle. A start that leaks into a busy run shows as a wrong plaintext or a shifted completion.

// File: rtl/nlfsr_dec_pkg.sv
package nlfsr_dec_pkg;

    localparam int DEF_BLK_W  = 32;
    localparam int DEF_KEY_W  = 64;
    localparam int DEF_ROUNDS = 528;

    localparam int          NLF_IN  = 5;
    localparam logic [31:0] NLF_LUT = 32'h3A5C742E;
    // listed from most significant index bit down
    localparam int NLF_TAP [NLF_IN] = '{30, 25, 19, 8, 0};

    localparam int LIN_TAP_A = 31;
    localparam int LIN_TAP_B = 15;
    localparam int KEY_TAP   = 15;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/nlfsr_nlf.sv
module nlfsr_nlf
    import nlfsr_dec_pkg::*;
#(
    parameter int          IN_W  = NLF_IN,
    parameter logic [31:0] TABLE = NLF_LUT
) (
    input  logic [IN_W-1:0] idx_i,
    output logic            bit_o
);
    localparam int ENTRIES = 1 << IN_W;

    logic [ENTRIES-1:0] table_w;
    assign table_w = TABLE[ENTRIES-1:0];

    always_comb begin
        bit_o = table_w[idx_i];
    end
endmodule

// File: rtl/nlfsr_round.sv
module nlfsr_round
    import nlfsr_dec_pkg::*;
#(
    parameter int BLK_W = DEF_BLK_W
) (
    input  logic [BLK_W-1:0] state_i,
    input  logic             key_bit_i,
    output logic             fb_o
);
    logic [NLF_IN-1:0] idx_w;
    logic              nlf_w;

    // gather the nonlinear taps, first listed tap lands in the top index bit
    for (genvar g = 0; g < NLF_IN; g++) begin : g_tap
        assign idx_w[NLF_IN-1-g] = state_i[NLF_TAP[g]];
    end

    nlfsr_nlf #(
        .IN_W  (NLF_IN),
        .TABLE (NLF_LUT)
    ) u_nlf (
        .idx_i (idx_w),
        .bit_o (nlf_w)
    );

    always_comb begin
        fb_o = state_i[LIN_TAP_A] ^ state_i[LIN_TAP_B] ^ key_bit_i ^ nlf_w;
    end
endmodule

// File: rtl/nlfsr_ctrl.sv
module nlfsr_ctrl
    import nlfsr_dec_pkg::*;
#(
    parameter int ROUNDS = DEF_ROUNDS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int                CNT_W = $clog2(ROUNDS);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(ROUNDS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] rnd;
        logic             done;
    } ctrl_s;

    ctrl_s c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        load_o   = 1'b0;
        step_o   = 1'b0;
        unique case (c_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load_o    = 1'b1;
                    c_d.phase = PH_RUN;
                    c_d.rnd   = '0;
                end
            end
            PH_RUN: begin
                step_o = 1'b1;
                if (c_q.rnd == LAST) begin
                    c_d.phase = PH_IDLE;
                    c_d.done  = 1'b1;
                end else begin
                    c_d.rnd = c_q.rnd + 1'b1;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{phase: PH_IDLE, rnd: '0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o = (c_q.phase == PH_RUN);
    assign done_o = c_q.done;

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |=> !c_q.done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |-> (c_q.phase == PH_IDLE));

    assert_fall_gives_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> c_q.done);

    assert_round_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (c_q.rnd <= LAST));

    assert_ignore_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (c_q.rnd != LAST)) |=>
            (busy_o && (c_q.rnd == $past(c_q.rnd) + 1'b1)));
endmodule

// File: rtl/nlfsr_decryptor.sv
module nlfsr_decryptor
    import nlfsr_dec_pkg::*;
#(
    parameter int BLK_W  = DEF_BLK_W,
    parameter int KEY_W  = DEF_KEY_W,
    parameter int ROUNDS = DEF_ROUNDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] cipher_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [BLK_W-1:0] plain_o
);
    typedef struct packed {
        logic [BLK_W-1:0] state;
        logic [KEY_W-1:0] key;
    } dp_s;

    dp_s  dp_d, dp_q;
    logic load_w, step_w, fb_w;

    nlfsr_ctrl #(
        .ROUNDS (ROUNDS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load_w),
        .step_o  (step_w),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    nlfsr_round #(
        .BLK_W (BLK_W)
    ) u_round (
        .state_i   (dp_q.state),
        .key_bit_i (dp_q.key[KEY_TAP]),
        .fb_o      (fb_w)
    );

    always_comb begin
        dp_d = dp_q;
        if (load_w) begin
            dp_d.state = cipher_i;
            dp_d.key   = key_i;
        end else if (step_w) begin
            dp_d.state = {dp_q.state[BLK_W-2:0], fb_w};
            dp_d.key   = {dp_q.key[KEY_W-2:0], dp_q.key[KEY_W-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign plain_o = dp_q.state;

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && plain_o == $past(cipher_i)));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(plain_o));

    assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (plain_o[BLK_W-1:1] == $past(plain_o[BLK_W-2:0])));
endmodule

// File: tb/sim_nlfsr_decryptor.sv
module sim_nlfsr_decryptor;

    localparam int NV = 6;
    localparam logic [63:0] V_KEY [NV] = '{
        64'h5CEC6701B79FD949, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF,
        64'h0123456789ABCDEF, 64'hDEADBEEFCAFEF00D, 64'h8000000000000001};
    localparam logic [31:0] V_PT [NV] = '{
        32'hF741E2DB, 32'h00000000, 32'hFFFFFFFF,
        32'h12345678, 32'h80000001, 32'hA5A55A5A};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] cipher_i = '0;
    logic [63:0] key_i = '0;
    logic        busy_o, done_o;
    logic [31:0] plain_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    nlfsr_decryptor u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cipher_i(cipher_i),
        .key_i(key_i), .busy_o(busy_o), .done_o(done_o), .plain_o(plain_o));

    localparam logic [31:0] LUT = 32'h3A5C742E;

    function automatic logic [31:0] ref_dec(input logic [31:0] c, input logic [63:0] k);
        logic [31:0] x = c;
        for (int r = 0; r < 528; r++) begin
            logic fb;
            fb = x[31] ^ x[15] ^ k[(15 - r + 640) % 64]
               ^ LUT[{x[30], x[25], x[19], x[8], x[0]}];
            x = {x[30:0], fb};
        end
        return x;
    endfunction

    function automatic logic [31:0] ref_enc(input logic [31:0] p, input logic [63:0] k);
        logic [31:0] x = p;
        for (int i = 0; i < 528; i++) begin
            logic fb;
            fb = x[0] ^ x[16] ^ k[i % 64] ^ LUT[{x[31], x[26], x[20], x[9], x[1]}];
            x = {fb, x[31:1]};
        end
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // runs one decryption; inj >= 0 raises a foreign start in that busy cycle
    task automatic run_dec(input logic [63:0] k, input logic [31:0] c, input int inj,
                           output logic [31:0] res, output int cyc,
                           output bit busy_first, output bit busy_end, output bit pulse_ok);
        @(negedge clk);
        start_i = 1'b1; cipher_i = c; key_i = k;
        @(negedge clk);
        start_i = 1'b0;
        busy_first = busy_o;
        cyc = 0;
        while (!done_o && cyc < 1000) begin
            if (cyc == inj) begin
                start_i = 1'b1; cipher_i = ~c; key_i = ~k;
            end
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        res = plain_o;
        busy_end = busy_o;
        @(negedge clk);
        pulse_ok = !done_o;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] res, res2;
        int cyc;
        bit b0, b1, pok;

        #1;
        check(busy_o == 1'b0 && done_o == 1'b0, "R1 reset flags", {busy_o, done_o}, 0);
        check(plain_o == 32'h0, "R1 reset plain", plain_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // vector table: decryption of the encrypted word must give the word back
        for (int v = 0; v < NV; v++) begin
            logic [31:0] ct;
            ct = ref_enc(V_PT[v], V_KEY[v]);
            run_dec(V_KEY[v], ct, -1, res, cyc, b0, b1, pok);
            check(b0, "R2 busy after start", b0, 1);
            check(cyc == 528, "R3 latency", cyc, 528);
            check(!b1, "R3 busy low at done", b1, 0);
            check(pok, "R3 one-cycle done", pok, 1);
            check(res == ref_dec(ct, V_KEY[v]), "R4 model match", res, ref_dec(ct, V_KEY[v]));
            check(res == V_PT[v], "R5 round trip", res, V_PT[v]);
        end

        // R7: hold after done while inputs wander
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cipher_i = 32'h13579BDF ^ 32'(i); key_i = {32'(i), 32'hFFFF0000};
        end
        check(plain_o == V_PT[NV-1], "R7 hold plain", plain_o, V_PT[NV-1]);
        check(!busy_o && !done_o, "R7 stays idle", {busy_o, done_o}, 0);

        // R6: foreign starts mid-run and in the final round
        run_dec(V_KEY[3], 32'hC0FFEE11, 100, res, cyc, b0, b1, pok);
        check(res == ref_dec(32'hC0FFEE11, V_KEY[3]), "R6 mid start ignored", res,
              ref_dec(32'hC0FFEE11, V_KEY[3]));
        check(cyc == 528, "R6 mid start latency", cyc, 528);
        run_dec(V_KEY[4], 32'h0BADF00D, 527, res, cyc, b0, b1, pok);
        check(res == ref_dec(32'h0BADF00D, V_KEY[4]), "R6 last-round start ignored", res,
              ref_dec(32'h0BADF00D, V_KEY[4]));
        check(cyc == 528 && pok, "R6 last-round latency", cyc, 528);
        check(!busy_o, "R6 no restart", busy_o, 0);

        // R8: back-to-back runs
        run_dec(V_KEY[0], 32'h11111111, -1, res, cyc, b0, b1, pok);
        @(negedge clk);
        start_i = 1'b1; cipher_i = 32'h22222222; key_i = V_KEY[2];
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R8 restart accepted", busy_o, 1);
        cyc = 0;
        while (!done_o && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        res2 = plain_o;
        check(cyc == 528, "R8 restart latency", cyc, 528);
        check(res2 == ref_dec(32'h22222222, V_KEY[2]), "R8 restart result", res2,
              ref_dec(32'h22222222, V_KEY[2]));

        // R1: reset in the middle of a run
        @(negedge clk);
        start_i = 1'b1; cipher_i = 32'hFACEB00C; key_i = V_KEY[1];
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!busy_o && !done_o, "R1 mid-run reset flags", {busy_o, done_o}, 0);
        check(plain_o == 32'h0, "R1 mid-run reset plain", plain_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o, "R1 idle after reset", busy_o, 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule